// File: doc/BRIEF.md
# Self-Calibrating Line-Frequency Multiplier

This block turns a slow periodic input, nominally the 60 Hz mains, into a much faster pulse train: every rising edge of the input starts a burst of a fixed number of output pulses (100 by default). The pulse rate is set by a 4-bit trim code. Each code selects a half-period in system clocks, and a larger code gives a shorter half-period, so the pulses come faster.

The block tunes the trim code itself so that one burst just fills one input period. Two cases count as too slow, and each raises the code by one: the input is still high when the burst ends, or a new input edge arrived while the burst was running. Otherwise the block measures the idle gap between the end of the burst and the next input rising edge. A gap longer than a fixed target lowers the code by one, and any other gap raises it by one. Once the loop has settled, counting the output over a 1 s gate reads the line frequency times the burst length, which gives 0.01 Hz resolution with the default burst.

The input passes through a two-flop synchronizer, and its rising edges are found in the system clock domain.

Top module: `line_freq_mult`

## Requirements
- R1: After reset `pulse_o` is low and `trim_o` equals TRIM_INIT (default 8). No pulse appears until the first input rising edge.
- R2: A rising edge of `line_i` that arrives while no burst is running starts a burst of exactly PULSES output pulses.
- R3: Each pulse in a burst is high for H clocks and then low for H clocks, where H = BASE_HALF - STEP_HALF * code. The code is the value `trim_o` held when the burst started.
- R4: If `line_i` is still high when a burst ends, `trim_o` increases by one.
- R5: If `line_i` is low when a burst ends, the block counts the clocks until the next rising edge. If that count exceeds GAP_TARGET, `trim_o` decreases by one, and the same edge starts the next burst.
- R6: If the gap counted under R5 is not above GAP_TARGET, `trim_o` increases by one.
- R7: `trim_o` saturates at 15 and at 0 and never wraps. It changes by at most one step at a time.
- R8: An input rising edge that arrives during a burst does not restart or extend the burst. It makes that burst count as too slow (`trim_o` increases by one), and no new burst begins until a later rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Slow periodic input, asynchronous to clk_i |
| pulse_o | output | 1 | Multiplied pulse train, bursts of PULSES pulses |
| trim_o | output | 4 | Current rate trim code, larger means faster |

## Verification
The hardest states to reach are the two saturation ends of the trim code and the extra edges that arrive during a burst. In normal operation the loop stays near the middle of its range. The bench drives input periods computed from the burst length the current code should give: it chooses gaps far above the target to walk the code down to 0 and past it, and input highs longer than the burst to walk the code up to 15 and past it. It also produces a burst that is interrupted by several short input pulses and then followed by a long low. The bench checks the pulse count and the first pulse width of every burst, so the rate formula is covered at nearly every code value.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } lfm_state_e;
endpackage

// File: rtl/lfm_sync.sv
module lfm_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  // chain[SYNC_STAGES] holds the previous synchronized level for edge detection
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], async_i};
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise_o  = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/lfm_pulse_gen.sv
module lfm_pulse_gen #(
  parameter int PULSES    = 100,
  parameter int BASE_HALF = 200,
  parameter int STEP_HALF = 3,
  parameter int TRIM_W    = 4,
  localparam int HALF_W   = $clog2(BASE_HALF + 1),
  localparam int CNT_W    = $clog2(PULSES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [HALF_W-1:0] half_o
);
  logic [HALF_W-1:0] half_calc, half_q, hcnt_q;
  logic [CNT_W-1:0]  pcnt_q;
  logic              phase_q, busy_q, done_q;

  assign half_calc = HALF_W'(BASE_HALF - STEP_HALF * int'(trim_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b1;
        hcnt_q  <= '0;
        pcnt_q  <= '0;
        half_q  <= half_calc;
      end else if (busy_q) begin
        if (hcnt_q == half_q - 1'b1) begin
          hcnt_q <= '0;
          if (phase_q) begin
            phase_q <= 1'b0;
          end else if (pcnt_q == CNT_W'(PULSES - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            phase_q <= 1'b1;
            pcnt_q  <= pcnt_q + 1'b1;
          end
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = phase_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign half_o  = half_q;
endmodule

// File: rtl/lfm_trim_ctrl.sv
module lfm_trim_ctrl
  import lfm_pkg::*;
#(
  parameter int TRIM_W     = 4,
  parameter int TRIM_INIT  = 8,
  parameter int GAP_W      = 16,
  parameter int GAP_TARGET = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              level_i,
  input  logic              done_i,
  output logic              start_o,
  output logic [TRIM_W-1:0] trim_o
);
  lfm_state_e        st_q;
  logic [TRIM_W-1:0] trim_q;
  logic [GAP_W-1:0]  gap_q;
  logic              late_edge_q;

  assign start_o = rise_i && (st_q != ST_BURST);

  function automatic logic [TRIM_W-1:0] trim_up(input logic [TRIM_W-1:0] t);
    return (t == '1) ? t : t + 1'b1;
  endfunction

  function automatic logic [TRIM_W-1:0] trim_dn(input logic [TRIM_W-1:0] t);
    return (t == '0) ? t : t - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_ARMED;
      trim_q      <= TRIM_W'(TRIM_INIT);
      gap_q       <= '0;
      late_edge_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ARMED: begin
          if (rise_i) begin
            st_q        <= ST_BURST;
            late_edge_q <= 1'b0;
          end
        end
        ST_BURST: begin
          if (rise_i) late_edge_q <= 1'b1;
          if (done_i) begin
            if (level_i || late_edge_q || rise_i) begin
              trim_q <= trim_up(trim_q);
              st_q   <= ST_ARMED;
            end else begin
              gap_q <= '0;
              st_q  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (rise_i) begin
            trim_q      <= (gap_q > GAP_W'(GAP_TARGET)) ? trim_dn(trim_q) : trim_up(trim_q);
            st_q        <= ST_BURST;
            late_edge_q <= 1'b0;
          end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_ARMED;
      endcase
    end
  end

  assign trim_o = trim_q;
endmodule

// File: rtl/line_freq_mult.sv
module line_freq_mult #(
  parameter int PULSES      = 100,
  parameter int BASE_HALF   = 200,
  parameter int STEP_HALF   = 3,
  parameter int TRIM_INIT   = 8,
  parameter int GAP_TARGET  = 1000,
  parameter int GAP_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       pulse_o,
  output logic [3:0] trim_o
);
  localparam int TRIM_W = 4;
  localparam int HALF_W = $clog2(BASE_HALF + 1);

  logic              line_lvl, line_rise;
  logic              start, busy, done;
  logic [HALF_W-1:0] half_q;
  logic [TRIM_W-1:0] trim;

  lfm_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (line_i),
    .level_o (line_lvl),
    .rise_o  (line_rise)
  );

  lfm_trim_ctrl #(
    .TRIM_W     (TRIM_W),
    .TRIM_INIT  (TRIM_INIT),
    .GAP_W      (GAP_W),
    .GAP_TARGET (GAP_TARGET)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (line_rise),
    .level_i (line_lvl),
    .done_i  (done),
    .start_o (start),
    .trim_o  (trim)
  );

  lfm_pulse_gen #(
    .PULSES    (PULSES),
    .BASE_HALF (BASE_HALF),
    .STEP_HALF (STEP_HALF),
    .TRIM_W    (TRIM_W)
  ) u_pgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .trim_i  (trim),
    .pulse_o (pulse_o),
    .busy_o  (busy),
    .done_o  (done),
    .half_o  (half_q)
  );

  assign trim_o = trim;
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
  parameter int TRIM_W = 4,
  parameter int HALF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_i,
  input logic [TRIM_W-1:0] trim_i,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [HALF_W-1:0] half_i
);
  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |-> busy_i);

  assert_burst_end_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!pulse_i && !busy_i && $past(busy_i)));

  assert_rate_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(half_i));

  assert_trim_on_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_i != $past(trim_i)) |-> ($past(done_i) || $past(start_i)));

  assert_trim_unit_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_i != $past(trim_i)) |->
      ((int'(trim_i) == int'($past(trim_i)) + 1) || (int'(trim_i) == int'($past(trim_i)) - 1)));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_i);
endmodule

bind line_freq_mult lfm_checker #(.TRIM_W(TRIM_W), .HALF_W(HALF_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pulse_i (pulse_o),
  .trim_i  (trim_o),
  .start_i (start),
  .busy_i  (busy),
  .done_i  (done),
  .half_i  (half_q)
);

// File: tb/sim_line_freq_mult.sv
module sim_line_freq_mult;
  localparam int N_P      = 4;
  localparam int BASE_P   = 24;
  localparam int STEP_P   = 1;
  localparam int INIT_P   = 8;
  localparam int TARGET_P = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       pulse;
  logic [3:0] trim;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  int  code = INIT_P;
  bit  gap_mode = 1'b0;
  int  gap_est = 0;

  int  pcnt = 0;
  int  fw = 0;
  bit  in_first = 1'b0;
  logic pulse_prev = 1'b0;

  always #2 clk = ~clk;

  line_freq_mult #(
    .PULSES     (N_P),
    .BASE_HALF  (BASE_P),
    .STEP_HALF  (STEP_P),
    .TRIM_INIT  (INIT_P),
    .GAP_TARGET (TARGET_P),
    .GAP_W      (12)
  ) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .line_i  (line),
    .pulse_o (pulse),
    .trim_o  (trim)
  );

  // pulse monitor, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (pulse && !pulse_prev) begin
      if (pcnt == 0) begin
        in_first = 1'b1;
        fw = 1;
      end else begin
        in_first = 1'b0;
      end
      pcnt = pcnt + 1;
    end else if (in_first) begin
      if (pulse) fw = fw + 1;
      else in_first = 1'b0;
    end
    pulse_prev = pulse;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic int burst_len();
    return 2 * N_P * (BASE_P - STEP_P * code);
  endfunction

  task automatic run_period(input int h, input int l);
    int hh, b;
    string tag;
    hh = BASE_P - STEP_P * code;
    b = 2 * N_P * hh;
    tag = "R2";
    if (gap_mode) begin
      if (gap_est > TARGET_P) begin
        tag = (code == 0) ? "R7" : "R5";
        code = (code > 0) ? code - 1 : 0;
      end else begin
        tag = (code == 15) ? "R7" : "R6";
        code = (code < 15) ? code + 1 : 15;
      end
    end
    pcnt = 0;
    fw = 0;
    drive(1'b1, h);
    drive(1'b0, l);
    check("R2 pulse count", pcnt, N_P);
    check("R3 first pulse width", fw, hh);
    if (h > b) begin
      tag = (code == 15) ? "R7" : "R4";
      code = (code < 15) ? code + 1 : 15;
      gap_mode = 1'b0;
    end else begin
      gap_mode = 1'b1;
      gap_est = h + l - b;
    end
    check(tag, int'(trim), code);
  endtask

  task automatic gap_period(input int gap);
    int b;
    b = burst_len();
    run_period(30, b + gap - 30);
  endtask

  task automatic slow_period();
    int b;
    b = burst_len();
    run_period(b + 20, 30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hh, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1: quiet after reset
    check("R1 pulse idle", int'(pulse), 0);
    check("R1 trim init", int'(trim), INIT_P);
    check("R1 no pulses", pcnt, 0);

    // walk code down past 0 with long gaps (R5, R7)
    for (int i = 0; i < 11; i++) gap_period(TARGET_P + 20);
    // one too-slow period to re-arm (R4)
    slow_period();

    // R8: extra edges during a burst
    hh = BASE_P - STEP_P * code;
    b = 2 * N_P * hh;
    pcnt = 0;
    fw = 0;
    drive(1'b1, 10);
    drive(1'b0, 10);
    drive(1'b1, 10);
    drive(1'b0, 10);
    drive(1'b1, 10);
    drive(1'b0, b + 40);
    check("R8 pulse count", pcnt, N_P);
    check("R8 first pulse width", fw, hh);
    code = (code < 15) ? code + 1 : 15;
    gap_mode = 1'b0;
    check("R8 trim", int'(trim), code);

    // walk code up past 15 with long highs (R4, R7)
    for (int i = 0; i < 16; i++) slow_period();
    // short gaps at the top (R6, R7), then long and short mix
    for (int i = 0; i < 3; i++) gap_period(TARGET_P - 20);
    for (int i = 0; i < 4; i++) gap_period(TARGET_P + 20);
    for (int i = 0; i < 3; i++) gap_period(TARGET_P - 20);
    slow_period();
    gap_period(TARGET_P + 20);
    slow_period();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule